// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins arranged as two banks of eight. A host reaches it through a byte-wide register bus. Each pin has two registers. The output-control register sets direction, drive type, pull resistor choice and output level. The input-control register selects which edges raise an event, and it returns the pin's synchronized level. The analog pull network is outside this block: the pull choice leaves the block only as control outputs to the pad ring.

Pad inputs pass through a synchronizer before edge detection. A detected edge latches into the pin's bit in its bank's pending register. Software clears a pending bit by writing a 1 to it. Two mask registers exist per bank. Only the first mask set decides which pending bits reach the single interrupt output. The second set is storage that software can write and read back.

The bus carries requests and responses as two valid/ready streams:
- A request moves on a cycle in which `req_valid` and `req_ready` are both high.
- A write produces no response.
- A read produces exactly one response beat one cycle after it is accepted.
- That response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high.
- While a response waits for `rsp_ready`, `req_ready` stays low, so the block never has more than one read in flight.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and every `pad_oe` bit is 0.
- R2: The output-control registers sit at address 0x2B+n for pin n = 0..7 and at 0x3B+(n-8) for pin n = 8..15. Writable bits 5:0 read back as written; bits 7:6 read as 0.
- R2 (continued): Bit 3 drives `pull_en`, bits 2:1 drive `pull_sel[2n+1:2n]`, and bit 0 drives `pad_out`.
- R3: `pad_oe` for a pin follows direction bit 5 when bit 4 (open-drain) is 0. When bit 4 is 1, `pad_oe` is high only while bit 5 is 1 and bit 0 is 0.
- R4: The input-control registers sit at 0x33+n for pins 0..7 and at 0x43+(n-8) for pins 8..15. Bits 2:1 hold the edge mode and read back as written. Bit 0 reads the pad level after a two-flop synchronizer. Other bits read as 0.
- R5: The edge mode selects which events are latched: 00 none, 01 falling, 10 rising, 11 both. A latched event sets bit (n mod 8) of the pending register of bank n/8.
- R6: The pending registers are at 0x0B (bank 0) and 0x0C (bank 1). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: If an edge event and a write-1 clear hit the same bit in the same cycle, the bit stays set.
- R8: The first mask set is at 0x19/0x1A and the second at 0x1B/0x1C. All four registers read back as written. A 1 in the first set blocks that pin from `irq`. The second set has no effect on `irq`.
- R9: `irq` is the OR of all pending bits whose first-set mask bit is 0. A pending bit is set regardless of its mask.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumed |
| rsp_rdata | output | 8 | Read response data |
| pad_in | input | 16 | Pad input levels, asynchronous |
| pad_out | output | 16 | Pad output level per pin |
| pad_oe | output | 16 | Pad output enable per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_sel | output | 32 | Two-bit pull select per pin |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The pending register is the state that matters. A wrong set, clear or priority decision shows up on `irq` in the cycle after the edge reaches the end of the synchronizer, which is three clock edges after the pad changes. It also shows up in the next read of the pending address.

A corrupted configuration register shows up at once on `pad_oe`, `pad_out` or the pull outputs, with no bus traffic needed. An error in the synchronizer or edge detector can stay hidden until the pin's edge mode is enabled. For that reason, each mode is exercised against both edge directions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int CFG_W       = 6;
  localparam int BANK_STRIDE = 16;

  localparam logic [ADDR_W-1:0] OUT_BASE   = 8'h2B;
  localparam logic [ADDR_W-1:0] IN_BASE    = 8'h33;
  localparam logic [ADDR_W-1:0] PEND_BASE  = 8'h0B;
  localparam logic [ADDR_W-1:0] MASKA_BASE = 8'h19;
  localparam logic [ADDR_W-1:0] MASKB_BASE = 8'h1B;

  // Output-control fields; the bit order is the register layout.
  typedef struct packed {
    logic       dir;         // bit 5: 1 = drive the pad
    logic       open_drain;  // bit 4
    logic       pull_on;     // bit 3
    logic [1:0] pull_kind;   // bits 2:1
    logic       level;       // bit 0
  } out_cfg_t;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  function automatic logic [ADDR_W-1:0] pin_addr(logic [ADDR_W-1:0] base, int bank, int idx);
    return base + ADDR_W'(bank * BANK_STRIDE + idx);
  endfunction

  function automatic logic [ADDR_W-1:0] bank_addr(logic [ADDR_W-1:0] base, int bank);
    return base + ADDR_W'(bank);
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_in,
  input  logic [1:0] mode,
  output logic       level,
  output logic       evt
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;
  logic                   rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], pad_in};
      prev  <= level;
    end
  end

  assign level = chain[SYNC_STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  always_comb begin
    case (mode)
      EDGE_FALL: evt = fall;
      EDGE_RISE: evt = rise;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_irq_pkg::*;
(
  input  out_cfg_t   cfg,
  output logic       oe,
  output logic       out,
  output logic       pull_en,
  output logic [1:0] pull_sel
);
  // Open drain only pulls low: release the pad whenever the level is 1.
  assign oe       = cfg.dir && (!cfg.open_drain || !cfg.level);
  assign out      = cfg.level;
  assign pull_en  = cfg.pull_on;
  assign pull_sel = cfg.pull_kind;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8,
  localparam int NP           = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic [NP-1:0]          pin_level,
  input  logic [NP-1:0]          pin_evt,
  output out_cfg_t [NP-1:0]      out_cfg,
  output logic [NP-1:0][1:0]     edge_mode,
  output logic [NP-1:0]          pend_q,
  output logic [NP-1:0]          mask_a,
  output logic [NP-1:0]          mask_b
);
  localparam int PPB = PINS_PER_BANK;

  logic              wr_fire, rd_fire;
  logic [NP-1:0]     clr_vec;
  logic [DATA_W-1:0] rd_mux;

  // One read in flight: a waiting response blocks every new request.
  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  always_comb begin
    clr_vec = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_fire && req_addr == bank_addr(PEND_BASE, b))
        clr_vec[b*PPB +: PPB] = req_wdata[PPB-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cfg   <= '0;
      edge_mode <= '0;
      mask_a    <= '0;
      mask_b    <= '0;
    end else if (wr_fire) begin
      for (int p = 0; p < NP; p++) begin
        if (req_addr == pin_addr(OUT_BASE, p / PPB, p % PPB))
          out_cfg[p] <= out_cfg_t'(req_wdata[CFG_W-1:0]);
        if (req_addr == pin_addr(IN_BASE, p / PPB, p % PPB))
          edge_mode[p] <= req_wdata[2:1];
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (req_addr == bank_addr(MASKA_BASE, b))
          mask_a[b*PPB +: PPB] <= req_wdata[PPB-1:0];
        if (req_addr == bank_addr(MASKB_BASE, b))
          mask_b[b*PPB +: PPB] <= req_wdata[PPB-1:0];
      end
    end
  end

  // A new event outranks a clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | pin_evt;
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NP; p++) begin
      if (req_addr == pin_addr(OUT_BASE, p / PPB, p % PPB))
        rd_mux = DATA_W'(out_cfg[p]);
      if (req_addr == pin_addr(IN_BASE, p / PPB, p % PPB))
        rd_mux = DATA_W'({edge_mode[p], pin_level[p]});
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (req_addr == bank_addr(PEND_BASE, b))  rd_mux = DATA_W'(pend_q[b*PPB +: PPB]);
      if (req_addr == bank_addr(MASKA_BASE, b)) rd_mux = DATA_W'(mask_a[b*PPB +: PPB]);
      if (req_addr == bank_addr(MASKB_BASE, b)) rd_mux = DATA_W'(mask_b[b*PPB +: PPB]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int NP           = NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NP-1:0]     pad_in,
  output logic [NP-1:0]     pad_out,
  output logic [NP-1:0]     pad_oe,
  output logic [NP-1:0]     pull_en,
  output logic [2*NP-1:0]   pull_sel,
  output logic              irq
);
  out_cfg_t [NP-1:0]  out_cfg;
  logic [NP-1:0][1:0] edge_mode;
  logic [NP-1:0]      pend_q, mask_a, mask_b;
  logic [NP-1:0]      pin_level, pin_evt, dir_vec;

  gpio_irq_regs #(
    .NUM_BANKS     (NUM_BANKS),
    .PINS_PER_BANK (PINS_PER_BANK)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .pin_level (pin_level),
    .pin_evt   (pin_evt),
    .out_cfg   (out_cfg),
    .edge_mode (edge_mode),
    .pend_q    (pend_q),
    .mask_a    (mask_a),
    .mask_b    (mask_b)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pin
    gpio_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in[p]),
      .mode   (edge_mode[p]),
      .level  (pin_level[p]),
      .evt    (pin_evt[p])
    );

    gpio_pad_drive u_drive (
      .cfg      (out_cfg[p]),
      .oe       (pad_oe[p]),
      .out      (pad_out[p]),
      .pull_en  (pull_en[p]),
      .pull_sel (pull_sel[2*p +: 2])
    );

    assign dir_vec[p] = out_cfg[p].dir;
  end

  // The second mask set (mask_b) is storage only.
  assign irq = |(pend_q & ~mask_a);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NP = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [7:0]    rsp_rdata,
  input logic          irq,
  input logic [NP-1:0] pad_oe,
  input logic [NP-1:0] dir_vec,
  input logic [NP-1:0] pend_q,
  input logic [NP-1:0] pend_set
);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R3
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_vec) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |=> ((pend_q & $past(pend_set)) == $past(pend_set)));

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(pend_set)) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .irq       (irq),
  .pad_oe    (pad_oe),
  .dir_vec   (dir_vec),
  .pend_q    (pend_q),
  .pend_set  (pin_evt)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [7:0]  rsp_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pull_en;
  logic [31:0] pull_sel;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per delivered response beat.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R11 unexpected response", 32'(rsp_rdata), 32'hDEAD);
      else chk(tag_q.pop_front(), 32'(rsp_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic bus(input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus(1'b1, a, d);
  endtask

  // Driver: pushes the expected value, then issues the read.
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
    exp_q.push_back(e);
    tag_q.push_back(r);
    bus(1'b0, a, 8'h00);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [7:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    rd(8'h2B, 8'h00, "R1 out ctrl 0");
    rd(8'h33, 8'h00, "R1 in ctrl 0");
    rd(8'h0B, 8'h00, "R1 pending");
    rd(8'h19, 8'h00, "R1 mask");

    // R2 output control storage and pin outputs
    wr(8'h2B, 8'hFF);
    rd(8'h2B, 8'h3F, "R2 upper bits zero");
    chk("R3 open-drain high releases pin0", 32'(pad_oe[0]), 0);
    wr(8'h42, 8'h2E);
    rd(8'h42, 8'h2E, "R2 pin15 readback");
    chk("R2 pull_en15", 32'(pull_en[15]), 1);
    chk("R2 pull_sel15", 32'(pull_sel[31:30]), 32'h3);
    chk("R2 pad_out15", 32'(pad_out[15]), 0);
    chk("R3 push-pull oe15", 32'(pad_oe[15]), 1);

    // R3 output enable rules on pin 3
    wr(8'h2E, 8'h31); chk("R3 od level1", 32'(pad_oe[3]), 0);
    wr(8'h2E, 8'h30); chk("R3 od level0", 32'(pad_oe[3]), 1);
    chk("R3 od out", 32'(pad_out[3]), 0);
    wr(8'h2E, 8'h21); chk("R3 pp out oe", 32'(pad_oe[3]), 1);
    chk("R3 pp out level", 32'(pad_out[3]), 1);
    wr(8'h2E, 8'h01); chk("R3 input no oe", 32'(pad_oe[3]), 0);
    wr(8'h2B, 8'h00);

    // R4 input control on pin 9, both edges
    wr(8'h44, 8'hFF);
    rd(8'h44, 8'h06, "R4 mode readback");
    pad_in[9] = 1'b1; settle();
    rd(8'h44, 8'h07, "R4 level readback");
    rd(8'h0C, 8'h02, "R5 both-edge rise");
    chk("R9 irq from pin9", 32'(irq), 1);
    wr(8'h0C, 8'h02);
    rd(8'h0C, 8'h00, "R6 clear bank1");
    chk("R9 irq cleared", 32'(irq), 0);
    wr(8'h44, 8'h00);

    // R5 edge modes on pin 0
    wr(8'h33, 8'h04);
    pad_in[0] = 1'b1; settle();
    rd(8'h0B, 8'h01, "R5 rising");
    wr(8'h0B, 8'h00);
    rd(8'h0B, 8'h01, "R6 write zero keeps");
    wr(8'h0B, 8'h01);
    rd(8'h0B, 8'h00, "R6 write one clears");
    wr(8'h33, 8'h02);
    pad_in[0] = 1'b0; settle();
    rd(8'h0B, 8'h01, "R5 falling");
    wr(8'h0B, 8'h01);
    pad_in[0] = 1'b1; settle();
    rd(8'h0B, 8'h00, "R5 rise ignored in fall mode");
    wr(8'h33, 8'h00);
    pad_in[0] = 1'b0; settle();
    pad_in[0] = 1'b1; settle();
    rd(8'h0B, 8'h00, "R5 disabled");
    pad_in[0] = 1'b0; settle();

    // R5 bank 1 pin 12 rising
    wr(8'h47, 8'h04);
    pad_in[12] = 1'b1; settle();
    rd(8'h0C, 8'h10, "R5 bank1 bit4");
    chk("R9 irq pin12", 32'(irq), 1);

    // R8 / R9 masking
    wr(8'h1A, 8'h10);
    chk("R8 first mask gates", 32'(irq), 0);
    rd(8'h0C, 8'h10, "R9 pending kept under mask");
    rd(8'h1A, 8'h10, "R8 mask A readback");
    wr(8'h1C, 8'hFF);
    wr(8'h1A, 8'h00);
    chk("R8 second mask no effect", 32'(irq), 1);
    rd(8'h1C, 8'hFF, "R8 mask B readback");
    wr(8'h1A, 8'h10);
    wr(8'h0C, 8'h10);
    pad_in[12] = 1'b0; settle();
    pad_in[12] = 1'b1; settle();
    rd(8'h0C, 8'h10, "R9 set while masked");
    chk("R9 masked irq low", 32'(irq), 0);
    wr(8'h0C, 8'h10);
    wr(8'h1A, 8'h00);

    // R7 set and clear in the same cycle on pin 1
    wr(8'h34, 8'h04);
    @(negedge clk); pad_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0B; req_wdata = 8'h02;
    @(negedge clk); req_valid = 1'b0;
    rd(8'h0B, 8'h02, "R7 set beats clear");
    chk("R7 irq", 32'(irq), 1);
    wr(8'h0B, 8'h02);
    rd(8'h0B, 8'h00, "R7 later clear");

    // R10 unmapped space
    rd(8'h00, 8'h00, "R10 read 0x00");
    rd(8'h4B, 8'h00, "R10 read 0x4B");
    rd(8'h2A, 8'h00, "R10 read 0x2A");
    rd(8'hFF, 8'h00, "R10 read 0xFF");
    wr(8'h4B, 8'hFF);
    wr(8'h1D, 8'hFF);
    rd(8'h42, 8'h2E, "R10 pin15 untouched");
    rd(8'h1C, 8'hFF, "R10 mask B untouched");
    chk("R10 oe untouched", 32'(pad_oe), 32'h8000);

    // R11 back-pressure on the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    exp_q.push_back(8'h2E); tag_q.push_back("R11 stalled data");
    bus(1'b0, 8'h42, 8'h00);
    held = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      chk("R11 req_ready low", 32'(req_ready), 0);
      chk("R11 rsp_valid held", 32'(rsp_valid), 1);
      chk("R11 rdata stable", 32'(rsp_rdata), 32'(held));
      @(negedge clk);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 all responses seen", 32'(exp_q.size()), 0);

    finish_run();
  end
endmodule